// File: doc/BRIEF.md
# Elevator Car Motion and Door Controller

This block is the motion sequencer for one elevator car. Each clock it compares the car's present floor with a single, already arbitrated target floor and decides whether the car climbs, descends or stands with its door open. After arriving at a target it holds the door open for a minimum dwell. The dwell is counted in pulses of a one-second tick, and the block only returns to its resting state once the dwell has run out.

A fire alarm input overrides everything. From any normal state the car is sent down to the lowest floor (floor 1) and the door opens there. The alarm sequence must complete before the car can leave the alarm. If the alarm drops while the car is still descending, the descent carries on. Normal service resumes only once the car stands at floor 1 with the door open and the alarm is low. All four outputs are registered together with the state, so a state change and its outputs appear on the same clock edge.

Top module: `elev_unit_ctrl`

## Requirements
- R1: A synchronous, active-high reset puts the controller at rest with the door open: up_o=0, down_o=0, open_o=1, tmr_start_o=0, and the dwell count cleared.
- R2: At rest (up=0, down=0, open=1), a target above the floor gives up_o=1, open_o=0 from the next edge. A target below the floor gives down_o=1, open_o=0. An equal target keeps the resting outputs.
- R3: While climbing, up_o stays 1 as long as the target is above the floor. On the first cycle it is not, the next edge gives up_o=0, open_o=1, tmr_start_o=1 (door dwell).
- R4: While descending in normal service, down_o stays 1 as long as the target is below the floor. On the first cycle it is not, the next edge enters the door dwell (down_o=0, open_o=1, tmr_start_o=1).
- R5: In the door dwell, tmr_start_o=1 and open_o=1. Ticks are counted from the cycle after entry, saturating at 10. The edge after the one that samples the tenth counted tick returns the car to rest (tmr_start_o=0, open_o=1).
- R6: open_o is never 1 while up_o or down_o is 1, and up_o and down_o are never both 1.
- R7: fire_i high in any normal state sends the car into alarm mode on the next edge. If the floor is above 1 the outputs become down_o=1, open_o=0; at floor 1 they become up_o=0, down_o=0, open_o=1, tmr_start_o=0.
- R8: In the alarm descent, down_o stays 1 while the floor is above 1. The edge after the floor reads 1 or less gives down_o=0, open_o=1.
- R9: Alarm mode is left only from the completed state (at floor 1, door open) and only when fire_i is low; the next edge returns to rest. A low fire_i during the alarm descent has no effect.
- R10: fire_i takes priority over any normal transition that falls in the same cycle, including dwell expiry and arrival at the target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| floor_i | input | 4 | Present car floor, unsigned, 1 is lowest |
| req_i | input | 4 | Resolved target floor, unsigned |
| fire_i | input | 1 | Fire alarm, level |
| tick_i | input | 1 | One-second pulse, one clock wide |
| up_o | output | 1 | Drive car upward |
| down_o | output | 1 | Drive car downward |
| open_o | output | 1 | Door open |
| tmr_start_o | output | 1 | Door dwell in progress |

## Verification
The alarm and the door dwell can resolve in the same cycle. The bench raises fire_i exactly in the cycle in which the dwell count reaches its limit, and again in the cycle in which the car arrives at its target. In both cases the next edge must show alarm-mode outputs rather than the rest or door outputs. A behavioural model that keeps its own state number and tick tally judges every cycle. It also covers a tick landing on the entry edge of the dwell, which must not be counted, and an alarm that drops mid-descent, which must not end the descent.

// File: rtl/elev_pkg.sv
package elev_pkg;

  typedef enum logic [2:0] {
    ST_REST   = 3'd0,
    ST_CLIMB  = 3'd1,
    ST_SINK   = 3'd2,
    ST_DWELL  = 3'd3,
    ST_F_DESC = 3'd4,
    ST_F_OPEN = 3'd5
  } ctrl_state_e;

  typedef struct packed {
    logic up;
    logic dn;
    logic door;
    logic tstart;
  } drive_t;

  // Moore output decode for a state
  function automatic drive_t drive_of(input ctrl_state_e st);
    drive_t d;
    d = '0;
    unique case (st)
      ST_REST:   d.door = 1'b1;
      ST_CLIMB:  d.up   = 1'b1;
      ST_SINK:   d.dn   = 1'b1;
      ST_DWELL:  begin d.door = 1'b1; d.tstart = 1'b1; end
      ST_F_DESC: d.dn   = 1'b1;
      ST_F_OPEN: d.door = 1'b1;
      default:   d.door = 1'b1;
    endcase
    return d;
  endfunction

  function automatic logic is_normal(input ctrl_state_e st);
    return (st == ST_REST) || (st == ST_CLIMB) || (st == ST_SINK) || (st == ST_DWELL);
  endfunction

endpackage

// File: rtl/elev_dwell_timer.sv
module elev_dwell_timer #(
  parameter int DWELL_SECS = 10,
  localparam int TMR_W = $clog2(DWELL_SECS + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic tick,
  output logic done
);
  logic [TMR_W-1:0] cnt_q;
  localparam logic [TMR_W-1:0] LIMIT = TMR_W'(DWELL_SECS);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
    end else if (tick && (cnt_q < LIMIT)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign done = run && (cnt_q >= LIMIT);
endmodule

// File: rtl/elev_next_state.sv
module elev_next_state
  import elev_pkg::*;
#(
  parameter int FLOOR_W    = 4,
  parameter int BASE_FLOOR = 1
) (
  input  ctrl_state_e        state_q,
  input  logic [FLOOR_W-1:0] floor_i,
  input  logic [FLOOR_W-1:0] req_i,
  input  logic               fire_i,
  input  logic               dwell_done,
  output ctrl_state_e        state_d
);
  localparam logic [FLOOR_W-1:0] BASE = FLOOR_W'(BASE_FLOOR);

  logic above, below, at_base;
  assign above   = req_i > floor_i;
  assign below   = req_i < floor_i;
  assign at_base = floor_i <= BASE;

  always_comb begin
    state_d = state_q;
    if (is_normal(state_q) && fire_i) begin
      state_d = at_base ? ST_F_OPEN : ST_F_DESC;
    end else begin
      unique case (state_q)
        ST_REST:   if (above) state_d = ST_CLIMB;
                   else if (below) state_d = ST_SINK;
        ST_CLIMB:  if (!above) state_d = ST_DWELL;
        ST_SINK:   if (!below) state_d = ST_DWELL;
        ST_DWELL:  if (dwell_done) state_d = ST_REST;
        ST_F_DESC: if (at_base) state_d = ST_F_OPEN;
        ST_F_OPEN: if (!fire_i) state_d = ST_REST;
        default:   state_d = ST_REST;
      endcase
    end
  end
endmodule

// File: rtl/elev_unit_ctrl.sv
module elev_unit_ctrl
  import elev_pkg::*;
#(
  parameter int FLOOR_W    = 4,
  parameter int DWELL_SECS = 10,
  parameter int BASE_FLOOR = 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [FLOOR_W-1:0] floor_i,
  input  logic [FLOOR_W-1:0] req_i,
  input  logic               fire_i,
  input  logic               tick_i,
  output logic               up_o,
  output logic               down_o,
  output logic               open_o,
  output logic               tmr_start_o
);
  ctrl_state_e state_q, state_d;
  drive_t      drv_d;
  logic        dwell_done;

  // named events for the checker
  logic in_dwell, in_f_desc, in_f_open, dwell_entry;
  assign in_dwell    = state_q == ST_DWELL;
  assign in_f_desc   = state_q == ST_F_DESC;
  assign in_f_open   = state_q == ST_F_OPEN;
  assign dwell_entry = (state_d == ST_DWELL) && !in_dwell;

  elev_dwell_timer #(.DWELL_SECS(DWELL_SECS)) u_tmr (
    .clk  (clk),
    .rst  (rst),
    .run  (in_dwell),
    .tick (tick_i),
    .done (dwell_done)
  );

  elev_next_state #(.FLOOR_W(FLOOR_W), .BASE_FLOOR(BASE_FLOOR)) u_ns (
    .state_q    (state_q),
    .floor_i    (floor_i),
    .req_i      (req_i),
    .fire_i     (fire_i),
    .dwell_done (dwell_done),
    .state_d    (state_d)
  );

  assign drv_d = drive_of(state_d);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_REST;
      up_o        <= 1'b0;
      down_o      <= 1'b0;
      open_o      <= 1'b1;
      tmr_start_o <= 1'b0;
    end else begin
      state_q     <= state_d;
      up_o        <= drv_d.up;
      down_o      <= drv_d.dn;
      open_o      <= drv_d.door;
      tmr_start_o <= drv_d.tstart;
    end
  end
endmodule

// File: rtl/elev_unit_ctrl_chk.sv
module elev_unit_ctrl_chk #(
  parameter int FLOOR_W    = 4,
  parameter int BASE_FLOOR = 1
) (
  input logic               clk,
  input logic               rst,
  input logic [FLOOR_W-1:0] floor_i,
  input logic [FLOOR_W-1:0] req_i,
  input logic               fire_i,
  input logic               up_o,
  input logic               down_o,
  input logic               open_o,
  input logic               tmr_start_o,
  input logic               in_dwell,
  input logic               in_f_desc,
  input logic               in_f_open,
  input logic               dwell_entry,
  input logic               dwell_done
);
  AST_RESET_REST: assert property (@(posedge clk) $fell(rst) |-> (open_o && !up_o && !down_o && !tmr_start_o)); // R1
  AST_CLIMB_HOLD: assert property (@(posedge clk) disable iff (rst) (up_o && !fire_i && (req_i > floor_i)) |=> up_o); // R3
  AST_SINK_HOLD: assert property (@(posedge clk) disable iff (rst) (down_o && !in_f_desc && !fire_i && (req_i < floor_i)) |=> down_o); // R4
  AST_DWELL_ENTRY: assert property (@(posedge clk) disable iff (rst) dwell_entry |=> (tmr_start_o && open_o)); // R5
  AST_DWELL_MIN: assert property (@(posedge clk) disable iff (rst) (in_dwell && !dwell_done && !fire_i) |=> in_dwell); // R5
  AST_DOOR_NO_MOVE: assert property (@(posedge clk) disable iff (rst) !(open_o && (up_o || down_o))); // R6
  AST_ONE_DIR: assert property (@(posedge clk) disable iff (rst) !(up_o && down_o)); // R6
  AST_FIRE_NO_CLIMB: assert property (@(posedge clk) disable iff (rst) fire_i |=> (!up_o && !tmr_start_o)); // R7
  AST_BASE_STOP: assert property (@(posedge clk) disable iff (rst) (in_f_desc && (floor_i <= FLOOR_W'(BASE_FLOOR))) |=> (in_f_open && open_o)); // R8
  AST_DESC_COMPLETES: assert property (@(posedge clk) disable iff (rst) in_f_desc |=> (in_f_desc || in_f_open)); // R9
  AST_OPEN_HELD: assert property (@(posedge clk) disable iff (rst) (in_f_open && fire_i) |=> in_f_open); // R9
endmodule

bind elev_unit_ctrl elev_unit_ctrl_chk #(.FLOOR_W(FLOOR_W), .BASE_FLOOR(BASE_FLOOR)) u_chk (
  .clk(clk), .rst(rst), .floor_i(floor_i), .req_i(req_i), .fire_i(fire_i),
  .up_o(up_o), .down_o(down_o), .open_o(open_o), .tmr_start_o(tmr_start_o),
  .in_dwell(in_dwell), .in_f_desc(in_f_desc), .in_f_open(in_f_open),
  .dwell_entry(dwell_entry), .dwell_done(dwell_done)
);

// File: tb/elev_unit_ctrl_bench.sv
module elev_unit_ctrl_bench;
  logic clk = 0, rst = 1, fire = 0, tick = 0;
  logic [3:0] floor_v = 4'd1, req_v = 4'd1;
  logic up, dn, op, ts;
  int checks = 0, errors = 0;
  bit done_flag = 0;

  always #10 clk = ~clk; // 50 MHz

  elev_unit_ctrl u_elev_unit_ctrl (
    .clk(clk), .rst(rst), .floor_i(floor_v), .req_i(req_v), .fire_i(fire),
    .tick_i(tick), .up_o(up), .down_o(dn), .open_o(op), .tmr_start_o(ts)
  );

  // reference: 0 rest, 1 climb, 2 sink, 3 dwell, 4 alarm descent, 5 alarm open
  int ms = 0, mtally = 0;
  always @(posedge clk) begin
    int nx;
    if (rst) begin ms = 0; mtally = 0; end
    else begin
      nx = ms;
      if (ms <= 3 && fire) nx = (floor_v > 1) ? 4 : 5;
      else case (ms)
        0: nx = (req_v > floor_v) ? 1 : (req_v < floor_v) ? 2 : 0;
        1: nx = (req_v > floor_v) ? 1 : 3;
        2: nx = (req_v < floor_v) ? 2 : 3;
        3: nx = (mtally >= 10) ? 0 : 3;
        4: nx = (floor_v <= 1) ? 5 : 4;
        5: nx = fire ? 5 : 0;
        default: nx = 0;
      endcase
      if (ms != 3) mtally = 0;
      else if (tick && mtally < 10) mtally++;
      ms = nx;
    end
  end

  function automatic string tag_of(int s);
    case (s)
      0: return "R2"; 1: return "R3"; 2: return "R4"; 3: return "R5";
      4: return "R8"; default: return "R9";
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%b exp=%b at %0t", tag, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    logic [3:0] e;
    if (!rst && !done_flag) begin
      case (ms)
        0: e = 4'b0010; 1: e = 4'b1000; 2: e = 4'b0100; 3: e = 4'b0011;
        4: e = 4'b0100; default: e = 4'b0010;
      endcase
      chk({up, dn, op, ts} == e, tag_of(ms), {up, dn, op, ts}, e);
      chk(!(op && (up || dn)) && !(up && dn), "R6", {up, dn, op, ts}, e);
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
      cyc(2);
    end
  endtask

  initial begin
    #200000000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    cyc(3);
    chk({up, dn, op, ts} == 4'b0010, "R1", {up, dn, op, ts}, 4'b0010);
    @(negedge clk); rst = 0;
    cyc(3); // equal target: stays at rest (R2)
    // climb 2 -> 5
    floor_v = 2; req_v = 5; cyc(4);
    chk(up === 1'b1, "R2", {up, dn, op, ts}, 4'b1000);
    floor_v = 3; cyc(3); floor_v = 5; tick = 1; // tick on entry edge: not counted
    @(negedge clk); tick = 0;
    chk(ts === 1'b1, "R3", {up, dn, op, ts}, 4'b0011);
    ticks(9); cyc(3);
    chk(ts === 1'b1, "R5", {up, dn, op, ts}, 4'b0011);
    ticks(1); cyc(2);
    chk(ts === 1'b0 && op === 1'b1, "R5", {up, dn, op, ts}, 4'b0010);
    // descend 5 -> 2, alarm on arrival cycle (R10)
    req_v = 2; cyc(3); floor_v = 4; cyc(2);
    floor_v = 2; fire = 1; @(negedge clk);
    chk(dn === 1'b1 && op === 1'b0, "R10", {up, dn, op, ts}, 4'b0100);
    fire = 0; cyc(3); // dropped mid-descent: ignored (R9)
    chk(dn === 1'b1, "R9", {up, dn, op, ts}, 4'b0100);
    floor_v = 1; cyc(2);
    chk(op === 1'b1 && dn === 1'b0, "R8", {up, dn, op, ts}, 4'b0010);
    cyc(2);
    // rest at 1, alarm at base floor: door stays open (R7)
    fire = 1; cyc(2);
    chk({up, dn, op, ts} == 4'b0010, "R7", {up, dn, op, ts}, 4'b0010);
    fire = 0; cyc(2);
    // climb to 6, let dwell reach limit and raise alarm in that cycle (R10)
    req_v = 6; cyc(3); floor_v = 6; cyc(2);
    ticks(9);
    @(negedge clk); tick = 1; @(negedge clk); tick = 0; fire = 1; // tally reaches 10 now
    @(negedge clk);
    chk(dn === 1'b1 && ts === 1'b0, "R10", {up, dn, op, ts}, 4'b0100);
    cyc(2); floor_v = 3; cyc(2); floor_v = 1; cyc(3);
    chk(op === 1'b1, "R9", {up, dn, op, ts}, 4'b0010);
    fire = 0; req_v = 1; @(negedge clk); cyc(1);
    chk({up, dn, op, ts} == 4'b0010, "R9", {up, dn, op, ts}, 4'b0010);
    // alarm from climbing (R7)
    req_v = 8; cyc(3); floor_v = 4; fire = 1; @(negedge clk);
    chk(dn === 1'b1 && up === 1'b0, "R7", {up, dn, op, ts}, 4'b0100);
    fire = 0; floor_v = 1; cyc(3); req_v = 1; cyc(3);
    // reset mid-motion
    req_v = 7; cyc(3); rst = 1; cyc(2);
    chk({up, dn, op, ts} == 4'b0010, "R1", {up, dn, op, ts}, 4'b0010);
    rst = 0; req_v = 1; cyc(3);
    done_flag = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule